// File: doc/BRIEF.md
# Dual-Window Shadow Configuration Bank

This block keeps the configuration of two overlay windows of a display controller. Each window has a shadow register set that software writes over a simple register bus, and an active set that feeds the pixel pipeline. Contents move from shadow to active only on a frame-sync pulse, so a frame never starts with a half-written configuration.

A transfer happens only after software sets a self-clearing update request in the global control register. Each window also has its own hold flag. While the flag is set, that window is left out of every transfer, and its pending changes wait. The request stays armed until a held window with pending changes has been released and copied. Reads always return shadow contents. A status field shows which windows have changes that are not yet applied.

Top module: `win_shadow_bank`

Register map (6-bit word address): bit 5 = 0 selects a window register, with bit 4 the window and bits 3:0 the index. Index 0 is the buffer base (32 bits). Indices 1 to 4 are coordinate pairs with X in bits CW-1:0 and Y in bits 16+CW-1:16: 1 is buffer width/height, 2 is read offset, 3 is the inclusive top-left corner and 4 is the inclusive bottom-right corner. Index 5 is alpha0 (24 bits) and index 6 is alpha1 (24 bits). Index 7 is the mode register: bit 0 enable, bit 1 burst select (1 = 8-word, 0 = 16-word), bits 7:4 pixel format. Index 8 is the colour key (24 bits, window 1 only). Address 0x20 is the global control register: bit 0 update request, bits 2:1 hold flags for window 0 and window 1, and bits 5:4 pending flags (read only).

## Requirements
- R1: A window register write lands in the shadow copy and reads back on the next cycle. The active outputs do not change until a transfer.
- R2: On a clock edge where vsync is high and the update request is set, every window whose hold flag is clear copies all of its shadow registers to its active outputs.
- R3: Writing 1 to control bit 0 sets the request; writing 0 leaves it alone. The request clears at the transfer edge unless a held window has pending changes.
- R4: A held window is not copied, keeps its pending flag, and keeps the request set. It is applied at the first vsync after its hold flag is cleared.
- R5: The hold flags are independent: one window transfers while the other is held.
- R6: A vsync pulse with no request set changes no active output.
- R7: Clearing a window's enable bit (mode bit 0) takes effect on the active output only at the next transfer.
- R8: Window 0 has no colour key: writes to its index 8 are ignored, read as zero and set no pending flag. Window 1's key keeps its low 24 bits.
- R9: Fields keep only their defined bits: coordinates are CW bits each, and the mode register keeps bits 0, 1 and 7:4. Burst select 1 drives win_burst8.
- R10: A window's pending flag (control bit 4 + window) is set by an accepted write to that window and cleared when that window is copied.
- R11: After reset, all shadow and active registers, hold flags, pending flags and the request are zero, and both windows are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (shadow contents or control/status) |
| vsync | input | 1 | Frame-boundary pulse |
| win_en | output | 2 | Active enable per window |
| win_burst8 | output | 2 | Active burst select per window (1 = 8-word) |
| win_fmt | output | 8 | Active pixel format, 4 bits per window |
| win_base | output | 64 | Active buffer base, 32 bits per window |
| win_width | output | 2*CW | Active buffer width |
| win_height | output | 2*CW | Active buffer height |
| win_offs_x | output | 2*CW | Active read offset X |
| win_offs_y | output | 2*CW | Active read offset Y |
| win_tl_x | output | 2*CW | Active top-left X (inclusive) |
| win_tl_y | output | 2*CW | Active top-left Y (inclusive) |
| win_br_x | output | 2*CW | Active bottom-right X (inclusive) |
| win_br_y | output | 2*CW | Active bottom-right Y (inclusive) |
| win_alpha0 | output | 48 | Active alpha0, 24 bits per window |
| win_alpha1 | output | 48 | Active alpha1, 24 bits per window |
| win1_key | output | 24 | Active colour key of window 1 |

## Verification
A write is registered at the edge where the strobe is high, so the read-back is due right after that edge. The bench drives every input on the falling edge and samples read data and outputs on the following falling edge. Active outputs and the cleared request or pending flags are due at the edge that samples vsync high. The bench therefore checks them on the falling edge right after the pulse, and checks that nothing moved on the falling edge before it.

// File: rtl/win_shadow_bank.sv
module win_shadow_bank #(
  parameter int CW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [5:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            vsync,
  output logic [1:0]      win_en,
  output logic [1:0]      win_burst8,
  output logic [7:0]      win_fmt,
  output logic [63:0]     win_base,
  output logic [2*CW-1:0] win_width,
  output logic [2*CW-1:0] win_height,
  output logic [2*CW-1:0] win_offs_x,
  output logic [2*CW-1:0] win_offs_y,
  output logic [2*CW-1:0] win_tl_x,
  output logic [2*CW-1:0] win_tl_y,
  output logic [2*CW-1:0] win_br_x,
  output logic [2*CW-1:0] win_br_y,
  output logic [47:0]     win_alpha0,
  output logic [47:0]     win_alpha1,
  output logic [23:0]     win1_key
);
  localparam int NREG = 9;
  localparam logic [31:0] XY_MASK = {{(16-CW){1'b0}}, {CW{1'b1}}, {(16-CW){1'b0}}, {CW{1'b1}}};

  function automatic logic [31:0] reg_mask(input logic w, input logic [3:0] i);
    case (i)
      4'd0:                   reg_mask = 32'hFFFF_FFFF;
      4'd1, 4'd2, 4'd3, 4'd4: reg_mask = XY_MASK;
      4'd5, 4'd6:             reg_mask = 32'h00FF_FFFF;
      4'd7:                   reg_mask = 32'h0000_00F3;
      4'd8:                   reg_mask = w ? 32'h00FF_FFFF : 32'h0;
      default:                reg_mask = 32'h0;
    endcase
  endfunction

  logic [31:0] shd [2][NREG];
  logic [31:0] act [2][NREG];
  logic [1:0]  prot, pend;
  logic        req;

  wire        glob   = bus_addr[5];
  wire        wsel   = bus_addr[4];
  wire [3:0]  ridx   = bus_addr[3:0];
  wire [31:0] wmask  = glob ? 32'h0 : reg_mask(wsel, ridx);
  wire        wr_win = bus_we && !glob && (wmask != 32'h0);
  wire        wr_ctl = bus_we && glob && (ridx == 4'd0);
  wire        xfer   = vsync && req;
  wire [1:0]  copy   = xfer ? ~prot : 2'b00;
  wire        held   = |(prot & pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < NREG; i++) begin
          shd[w][i] <= '0;
          act[w][i] <= '0;
        end
      prot <= '0;
      pend <= '0;
      req  <= 1'b0;
    end else begin
      for (int w = 0; w < 2; w++) begin
        for (int i = 0; i < NREG; i++) begin
          if (copy[w]) act[w][i] <= shd[w][i];
          if (wr_win && (wsel == w[0]) && (ridx == i[3:0]))
            shd[w][i] <= bus_wdata & wmask;
        end
        if (wr_win && (wsel == w[0])) pend[w] <= 1'b1;
        else if (copy[w])             pend[w] <= 1'b0;
      end
      if (wr_ctl) prot <= bus_wdata[2:1];
      if (wr_ctl && bus_wdata[0]) req <= 1'b1;
      else if (xfer && !held)     req <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (glob) begin
      if (ridx == 4'd0) bus_rdata = {26'd0, pend, 1'b0, prot, req};
    end else begin
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < NREG; i++)
          if ((wsel == w[0]) && (ridx == i[3:0])) bus_rdata = shd[w][i];
    end
  end

  logic unused_act;
  always_comb begin
    unused_act = 1'b0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NREG; i++) unused_act = unused_act ^ (^act[w][i]);
  end

  for (genvar w = 0; w < 2; w++) begin : g_out
    assign win_base  [w*32 +: 32] = act[w][0];
    assign win_width [w*CW +: CW] = act[w][1][CW-1:0];
    assign win_height[w*CW +: CW] = act[w][1][16 +: CW];
    assign win_offs_x[w*CW +: CW] = act[w][2][CW-1:0];
    assign win_offs_y[w*CW +: CW] = act[w][2][16 +: CW];
    assign win_tl_x  [w*CW +: CW] = act[w][3][CW-1:0];
    assign win_tl_y  [w*CW +: CW] = act[w][3][16 +: CW];
    assign win_br_x  [w*CW +: CW] = act[w][4][CW-1:0];
    assign win_br_y  [w*CW +: CW] = act[w][4][16 +: CW];
    assign win_alpha0[w*24 +: 24] = act[w][5][23:0];
    assign win_alpha1[w*24 +: 24] = act[w][6][23:0];
    assign win_en[w]              = act[w][7][0];
    assign win_burst8[w]          = act[w][7][1];
    assign win_fmt   [w*4 +: 4]   = act[w][7][7:4];
  end
  assign win1_key = act[1][8][23:0];
endmodule

// File: rtl/win_shadow_bank_checker.sv
module win_shadow_bank_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        vsync,
  input logic        req,
  input logic [1:0]  prot,
  input logic [1:0]  pend,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic [63:0] win_base,
  input logic [1:0]  win_en
);
  a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> ($stable(win_base) && $stable(win_en)));

  a_r4_hold_win0: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && prot[0]) |=> ($stable(win_base[31:0]) && $stable(win_en[0])));

  a_r5_hold_win1: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && prot[1]) |=> ($stable(win_base[63:32]) && $stable(win_en[1])));

  a_r3_req_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && req && ((prot & pend) == 2'b00) && !(bus_we && bus_addr == 6'h20)) |=> !req);

  a_r4_req_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && req && ((prot & pend) != 2'b00)) |=> req);

  a_r10_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && req && !prot[0] && !(bus_we && bus_addr[5:4] == 2'b00)) |=> !pend[0]);

  a_r8_key0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h08) |-> (bus_rdata == 32'h0));
endmodule

bind win_shadow_bank win_shadow_bank_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .req(req), .prot(prot), .pend(pend),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .win_base(win_base), .win_en(win_en)
);

// File: tb/win_shadow_bank_test.sv
module win_shadow_bank_test;
  localparam int CW = 13;
  logic clk = 0, rst_n = 0, bus_we = 0, vsync = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  win_en, win_burst8;
  logic [7:0]  win_fmt;
  logic [63:0] win_base;
  logic [2*CW-1:0] win_width, win_height, win_offs_x, win_offs_y, win_tl_x, win_tl_y, win_br_x, win_br_y;
  logic [47:0] win_alpha0, win_alpha1;
  logic [23:0] win1_key;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  win_shadow_bank #(.CW(CW)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h20, d); chk("R11 status", d, 0);
    rd(6'h00, d); chk("R11 shadow base", d, 0);
    chk("R11 enables", win_en, 0);
    chk("R11 base", win_base, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wr(6'h00, 32'h1234_5678);
    rd(6'h00, d); chk("R1 readback", d, 32'h1234_5678);
    chk("R1 active held", win_base, 0);
    rd(6'h20, d); chk("R10 pending set", d, 32'h10);
    pulse();
    chk("R6 no request no copy", win_base, 0);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    wr(6'h03, {16'd20, 16'd10});
    wr(6'h04, {16'd99, 16'd199});
    wr(6'h20, 32'h1);
    rd(6'h20, d); chk("R3 request set", d, 32'h11);
    chk("R2 not before vsync", win_base, 0);
    pulse();
    chk("R2 base copied", win_base[31:0], 32'h1234_5678);
    chk("R2 top-left x", win_tl_x[CW-1:0], 10);
    chk("R2 bottom-right y", win_br_y[CW-1:0], 99);
    rd(6'h20, d); chk("R3 R10 cleared", d, 0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    wr(6'h11, 32'hFFFF_FFFF);
    rd(6'h11, d); chk("R9 coord mask", d, 32'h1FFF_1FFF);
    wr(6'h17, 32'hFFFF_FFFF);
    rd(6'h17, d); chk("R9 mode mask", d, 32'hF3);
    wr(6'h20, 32'h1);
    pulse();
    chk("R9 burst8", win_burst8, 2'b10);
    chk("R9 format", win_fmt, 8'hF0);
    chk("R9 width", win_width[2*CW-1:CW], 13'h1FFF);
    chk("R9 enable", win_en, 2'b10);
  endtask

  task automatic t_protect();
    logic [31:0] d;
    wr(6'h20, 32'h2);
    wr(6'h00, 32'hAAAA_0000);
    wr(6'h10, 32'hBBBB_0000);
    wr(6'h20, 32'h3);
    pulse();
    chk("R5 win1 copied", win_base[63:32], 32'hBBBB_0000);
    chk("R4 win0 held", win_base[31:0], 32'h1234_5678);
    rd(6'h20, d); chk("R4 request kept", d, 32'h13);
    wr(6'h20, 32'h0);
    rd(6'h20, d); chk("R4 released", d, 32'h11);
    chk("R4 not before vsync", win_base[31:0], 32'h1234_5678);
    pulse();
    chk("R4 applied", win_base[31:0], 32'hAAAA_0000);
    rd(6'h20, d); chk("R4 R3 cleared", d, 0);
  endtask

  task automatic t_disable();
    wr(6'h17, 32'h0);
    wr(6'h20, 32'h1);
    chk("R7 still enabled", win_en[1], 1);
    pulse();
    chk("R7 disabled at vsync", win_en[1], 0);
  endtask

  task automatic t_key();
    logic [31:0] d;
    wr(6'h08, 32'h00AB_CDEF);
    rd(6'h08, d); chk("R8 win0 key zero", d, 0);
    rd(6'h20, d); chk("R8 no pending", d, 0);
    wr(6'h18, 32'h1234_5678);
    rd(6'h18, d); chk("R8 win1 key", d, 32'h0034_5678);
    wr(6'h20, 32'h1);
    pulse();
    chk("R8 win1 key active", win1_key, 24'h34_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_shadow(); t_commit(); t_masks();
    t_protect(); t_disable(); t_key();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule